// File: doc/BRIEF.md
# Serial Header-Inserting Frame Packer

This block accepts an unbroken serial bit stream, one bit per cycle in which the input enable is high, and cuts it into 20-bit data words. When a word completes, a 5-bit header taken from a parallel port is attached to it, and the 25-bit result is written into a small word buffer in that same step. On the output side a shifter takes one buffered frame at a time and sends it serially, header first, data after, most significant bit first.

Because every frame is 25/20 the length of the data it carries, the output side has to drain at least 5/4 as fast as the input fills. Both sides share one clock here: the input enable is high on at most four cycles in five, and the output may shift on every cycle its enable is high. Each word therefore passes through with a fixed latency rather than straight through. A word that completes while the buffer is full is discarded and latches a sticky overflow indication.

Top module: `hdr_frame_packer`

## Requirements
- R1: After reset, out_valid and out_start are low, buf_empty is high, and buf_full and overflow are low.
- R2: Every 20 input bits taken on cycles with in_en high form one word. Cycles with in_en low take no bit. The data part of a frame is sent in arrival order, so the first bit received is the first data bit sent.
- R3: The header is the value of hdr on the clock edge that takes the 20th bit of a word. It occupies the first 5 bit times of the frame, hdr[4] first.
- R4: A frame is exactly 25 valid bit times. out_start is high with out_valid on the first header bit only, and is never high on two cycles in a row.
- R5: If the buffer is empty and no frame is being sent, the first header bit is registered at the second clock edge after the edge that takes the 20th data bit.
- R6: With out_en held high and in_en high on at most 4 of every 5 cycles, frames follow each other with no idle bit time between them, no overflow occurs and no input bit is lost.
- R7: out_valid is low on the cycle after any cycle with out_en low. It is also low when the buffer is empty and no frame is in progress.
- R8: The buffer holds 4 frames. buf_full is high while it holds 4 and buf_empty is high while it holds none. The two are never high together.
- R9: A word that completes while buf_full is high is discarded, and the frames already stored still come out intact. overflow goes high and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Active-low synchronous reset |
| in_en | input | 1 | Input strobe: in_bit is taken on this edge |
| in_bit | input | 1 | Serial input data bit |
| hdr | input | 5 | Header attached to the word whose last bit is taken |
| out_en | input | 1 | Output enable: the shifter may advance one bit |
| out_bit | output | 1 | Serial output bit |
| out_valid | output | 1 | out_bit carries a frame bit |
| out_start | output | 1 | Marks the first header bit of a frame |
| buf_full | output | 1 | Word buffer holds its maximum number of frames |
| buf_empty | output | 1 | Word buffer holds no frame |
| overflow | output | 1 | Sticky: a completed word was discarded |

## Verification
The bench builds the block with its default parameters: 20 data bits, 5 header bits and a buffer of 4 frames. With these values a four-in-five input pattern exactly matches the drain rate, which brings the back-to-back frame case within reach. The shallow buffer lets five words fill it and overflow it within a few hundred cycles once the drain is held off. Changing the header every cycle shows that the sampling edge is the right one, and gaps in out_en show that the shifter holds its state while stalled.

// File: rtl/hfp_pkg.sv
package hfp_pkg;
    parameter int unsigned HFP_DATA_W = 20;
    parameter int unsigned HFP_HDR_W  = 5;
    parameter int unsigned HFP_DEPTH  = 4;
endpackage

// File: rtl/hfp_collector.sv
module hfp_collector #(
    parameter int unsigned DATA_W = 20,
    parameter int unsigned HDR_W  = 5,
    localparam int unsigned FRAME_W = DATA_W + HDR_W,
    localparam int unsigned CNT_W   = $clog2(DATA_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_en,
    input  logic               in_bit,
    input  logic [HDR_W-1:0]   hdr,
    output logic               word_vld,
    output logic [FRAME_W-1:0] word
);
    typedef struct packed {
        logic [DATA_W-2:0]  sh;
        logic [CNT_W-1:0]   cnt;
        logic               vld;
        logic [FRAME_W-1:0] word;
    } col_t;

    col_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (in_en) begin
            if (st_q.cnt == CNT_W'(DATA_W - 1)) begin
                // last bit of the word: header joins it in the same step
                st_d.word = {hdr, st_q.sh, in_bit};
                st_d.vld  = 1'b1;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
            st_d.sh = {st_q.sh[DATA_W-3:0], in_bit};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_vld = st_q.vld;
    assign word     = st_q.word;
endmodule

// File: rtl/hfp_word_fifo.sv
module hfp_word_fifo #(
    parameter int unsigned WIDTH = 25,
    parameter int unsigned DEPTH = 4,
    localparam int unsigned AW = $clog2(DEPTH),
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             full,
    output logic             empty,
    output logic             ovf
);
    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [AW-1:0]               wp;
        logic [AW-1:0]               rp;
        logic [CW-1:0]               cnt;
        logic                        ovf;
    } fifo_t;

    fifo_t st_d, st_q;
    logic  push_ok, pop_ok;

    always_comb begin
        st_d    = st_q;
        push_ok = push && (st_q.cnt != CW'(DEPTH));
        pop_ok  = pop && (st_q.cnt != '0);
        if (push_ok) begin
            st_d.mem[st_q.wp] = wdata;
            st_d.wp = (st_q.wp == AW'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
        end
        if (pop_ok) begin
            st_d.rp = (st_q.rp == AW'(DEPTH - 1)) ? '0 : st_q.rp + 1'b1;
        end
        case ({push_ok, pop_ok})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
        if (push && !push_ok) begin
            st_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.mem[st_q.rp];
    assign full  = (st_q.cnt == CW'(DEPTH));
    assign empty = (st_q.cnt == '0);
    assign ovf   = st_q.ovf;
endmodule

// File: rtl/hfp_shifter.sv
module hfp_shifter #(
    parameter int unsigned FRAME_W = 25,
    localparam int unsigned RW = $clog2(FRAME_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               out_en,
    input  logic               empty,
    input  logic [FRAME_W-1:0] frame,
    output logic               pop,
    output logic               out_bit,
    output logic               out_valid,
    output logic               out_start
);
    typedef struct packed {
        logic [FRAME_W-2:0] sreg;
        logic [RW-1:0]      rem;
        logic               obit;
        logic               vld;
        logic               sof;
    } shf_t;

    shf_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        st_d.sof = 1'b0;
        pop      = 1'b0;
        if (out_en) begin
            if (st_q.rem != '0) begin
                st_d.obit = st_q.sreg[FRAME_W-2];
                st_d.sreg = {st_q.sreg[FRAME_W-3:0], 1'b0};
                st_d.rem  = st_q.rem - 1'b1;
                st_d.vld  = 1'b1;
            end else if (!empty) begin
                // frame boundary: next frame starts with no idle bit
                pop       = 1'b1;
                st_d.obit = frame[FRAME_W-1];
                st_d.sreg = frame[FRAME_W-2:0];
                st_d.rem  = RW'(FRAME_W - 1);
                st_d.vld  = 1'b1;
                st_d.sof  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_bit   = st_q.obit;
    assign out_valid = st_q.vld;
    assign out_start = st_q.sof;
endmodule

// File: rtl/hdr_frame_packer.sv
module hdr_frame_packer #(
    parameter int unsigned DATA_W = hfp_pkg::HFP_DATA_W,
    parameter int unsigned HDR_W  = hfp_pkg::HFP_HDR_W,
    parameter int unsigned DEPTH  = hfp_pkg::HFP_DEPTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_en,
    input  logic             in_bit,
    input  logic [HDR_W-1:0] hdr,
    input  logic             out_en,
    output logic             out_bit,
    output logic             out_valid,
    output logic             out_start,
    output logic             buf_full,
    output logic             buf_empty,
    output logic             overflow
);
    localparam int unsigned FRAME_W = DATA_W + HDR_W;

    logic               word_vld;
    logic [FRAME_W-1:0] word;
    logic [FRAME_W-1:0] head_frame;
    logic               fifo_pop;

    hfp_collector #(.DATA_W(DATA_W), .HDR_W(HDR_W)) u_col (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_en    (in_en),
        .in_bit   (in_bit),
        .hdr      (hdr),
        .word_vld (word_vld),
        .word     (word)
    );

    hfp_word_fifo #(.WIDTH(FRAME_W), .DEPTH(DEPTH)) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (word_vld),
        .wdata (word),
        .pop   (fifo_pop),
        .rdata (head_frame),
        .full  (buf_full),
        .empty (buf_empty),
        .ovf   (overflow)
    );

    hfp_shifter #(.FRAME_W(FRAME_W)) u_shf (
        .clk       (clk),
        .rst_n     (rst_n),
        .out_en    (out_en),
        .empty     (buf_empty),
        .frame     (head_frame),
        .pop       (fifo_pop),
        .out_bit   (out_bit),
        .out_valid (out_valid),
        .out_start (out_start)
    );
endmodule

// File: rtl/hfp_checker.sv
module hfp_checker (
    input logic clk,
    input logic rst_n,
    input logic out_en,
    input logic out_valid,
    input logic out_start,
    input logic buf_full,
    input logic buf_empty,
    input logic overflow,
    input logic word_vld,
    input logic fifo_pop
);
    // R4: a frame start is always a valid bit
    a_r4_start_has_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_start |-> out_valid);

    // R4: starts are at least a frame apart, never adjacent
    a_r4_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        out_start |=> !out_start);

    // R7: a stalled output side produces no valid bit
    a_r7_stall_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |=> !out_valid);

    // R8: full and empty exclude each other
    a_r8_full_empty_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(buf_full && buf_empty));

    // R8: a full buffer stays full until something leaves
    a_r8_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_full && !fifo_pop) |=> buf_full);

    // R9: overflow is sticky
    a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    // R9: overflow only rises after a word met a full buffer
    a_r9_ovf_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> $past(buf_full && word_vld));
endmodule

bind hdr_frame_packer hfp_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_en    (out_en),
    .out_valid (out_valid),
    .out_start (out_start),
    .buf_full  (buf_full),
    .buf_empty (buf_empty),
    .overflow  (overflow),
    .word_vld  (word_vld),
    .fifo_pop  (fifo_pop)
);

// File: tb/sim_hdr_frame_packer.sv
module sim_hdr_frame_packer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_en = 1'b0;
    logic       in_bit = 1'b0;
    logic [4:0] hdr = '0;
    logic       out_en = 1'b0;
    logic       out_bit, out_valid, out_start, buf_full, buf_empty, overflow;

    hdr_frame_packer u0 (
        .clk(clk), .rst_n(rst_n), .in_en(in_en), .in_bit(in_bit), .hdr(hdr),
        .out_en(out_en), .out_bit(out_bit), .out_valid(out_valid),
        .out_start(out_start), .buf_full(buf_full), .buf_empty(buf_empty),
        .overflow(overflow)
    );

    always #10 clk = ~clk;

    int   n_vec = 0;
    int   n_bad = 0;
    int   cyc = 0;
    int   slot = 0;
    int   pos = 0;
    bit   exp_q[$];
    bit   lat_arm = 0;
    int   lat_exp = 0;
    bit   b2b_arm = 0;
    int   last_start = -1;
    logic en_seen = 1'b0;
    bit   done = 0;

    always @(posedge clk) begin
        cyc     <= cyc + 1;
        en_seen <= out_en;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic logic [19:0] word_of(input int k);
        return 20'((k * 32'h9E37) ^ (32'h5A5A5 >> (k % 4)));
    endfunction

    // driver: sends one word, pushing its expected frame into the scoreboard
    task automatic send_word(input logic [19:0] data, input int period,
                             input bit keep, input bit arm);
        logic [4:0] h;
        h = '0;
        for (int i = 0; i < 20; i++) begin
            if (period > 0 && (slot % period) == period - 1) begin
                @(negedge clk);
                in_en = 1'b0;
                hdr   = 5'(cyc * 3 + 1);
                slot++;
            end
            @(negedge clk);
            in_en  = 1'b1;
            in_bit = data[19-i];
            h      = 5'(cyc * 7 + 3);
            hdr    = h;
            slot++;
        end
        if (arm) begin
            lat_arm = 1;
            lat_exp = cyc + 3;
        end
        if (keep) begin
            for (int j = 4; j >= 0; j--) exp_q.push_back(h[j]);
            for (int j = 19; j >= 0; j--) exp_q.push_back(data[j]);
        end
    endtask

    task automatic idle_in();
        @(negedge clk);
        in_en = 1'b0;
    endtask

    task automatic wait_drain();
        for (int k = 0; k < 2000 && exp_q.size() != 0; k++) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R2 frames drained", exp_q.size(), 0);
    endtask

    // monitor: pops the scoreboard as valid bits appear
    always @(negedge clk) begin
        if (rst_n) begin
            if (!en_seen) chk(out_valid == 1'b0, "R7 valid after stall", out_valid, 0);
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7 unexpected valid bit", 1, 0);
                end else begin
                    bit e;
                    e = exp_q.pop_front();
                    if (pos < 5) chk(out_bit == e, "R3 header bit", out_bit, e);
                    else         chk(out_bit == e, "R2 data bit", out_bit, e);
                    chk(out_start == (pos == 0), "R4 start position", out_start, pos == 0);
                    if (out_start && lat_arm) begin
                        chk(cyc == lat_exp, "R5 first-frame latency", cyc, lat_exp);
                        lat_arm = 0;
                    end
                    if (out_start && b2b_arm && last_start >= 0)
                        chk(cyc - last_start == 25, "R6 frame spacing", cyc - last_start, 25);
                    if (out_start) last_start = cyc;
                    pos = (pos + 1) % 25;
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
        chk(out_start == 1'b0, "R1 out_start", out_start, 0);
        chk(buf_empty == 1'b1, "R1 buf_empty", buf_empty, 1);
        chk(buf_full == 1'b0, "R1 buf_full", buf_full, 0);
        chk(overflow == 1'b0, "R1 overflow", overflow, 0);

        // stream A: four-in-five input, continuous drain (R5, R6)
        out_en  = 1'b1;
        slot    = 0;
        b2b_arm = 1;
        send_word(20'hFFFFF, 5, 1, 1);
        send_word(20'h00000, 5, 1, 0);
        for (int k = 0; k < 6; k++) send_word(word_of(k), 5, 1, 0);
        idle_in();
        wait_drain();
        b2b_arm    = 0;
        last_start = -1;
        chk(overflow == 1'b0, "R6 no overflow at matched rate", overflow, 0);
        chk(out_valid == 1'b0, "R7 idle after drain", out_valid, 0);
        chk(buf_empty == 1'b1, "R8 empty after drain", buf_empty, 1);

        // stream B: sparse input, stalled output every third cycle (R2, R7)
        fork
            begin
                for (int k = 0; k < 250; k++) begin
                    @(negedge clk);
                    out_en = (k % 3) != 2;
                end
                @(negedge clk);
                out_en = 1'b1;
            end
            begin
                slot = 0;
                for (int k = 6; k < 11; k++) send_word(word_of(k), 2, 1, 0);
                idle_in();
            end
        join
        wait_drain();

        // single isolated word after idle, no gaps (R5)
        send_word(20'h80001, 0, 1, 1);
        idle_in();
        wait_drain();

        // overflow: drain held off (R8, R9)
        @(negedge clk);
        out_en = 1'b0;
        slot   = 0;
        for (int k = 20; k < 24; k++) send_word(word_of(k), 5, 1, 0);
        idle_in();
        repeat (3) @(negedge clk);
        chk(buf_full == 1'b1, "R8 full at four frames", buf_full, 1);
        chk(buf_empty == 1'b0, "R8 not empty when full", buf_empty, 0);
        chk(overflow == 1'b0, "R9 no overflow yet", overflow, 0);
        send_word(20'h12345, 5, 0, 0);
        idle_in();
        repeat (3) @(negedge clk);
        chk(overflow == 1'b1, "R9 overflow set", overflow, 1);
        chk(out_valid == 1'b0, "R7 no output while stalled", out_valid, 0);
        out_en = 1'b1;
        wait_drain();
        chk(overflow == 1'b1, "R9 overflow sticky", overflow, 1);
        chk(buf_empty == 1'b1, "R8 empty after overflow drain", buf_empty, 1);

        done = 1;
    end

    initial begin
        for (int t = 0; t < 150000 && !done; t++) @(posedge clk);
        if (!done) chk(1'b0, "watchdog expired", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule